// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Multi-Entry Queue

This block holds the capture state that goes with an uncorrectable error: a pointer to the error that came first, a four-dword header capture and a four-dword prefix capture. A detection block upstream sends each uncorrectable error as a one-cycle request. The request carries a one-hot status vector, the header and prefix dwords, and flags that say which of those are valid. The block sets the matching status bit. It then either loads the capture registers or, when queued recording is switched on and an earlier error is still unserviced, puts the request into a small FIFO.

Software services errors by writing ones to clear status bits. When the pointed-to bit is cleared, the oldest waiting error moves into the capture registers. Any attempt to clear the status bit of an error that is still waiting is undone. If the FIFO has no room, the block raises a one-cycle overflow pulse, which the classification logic turns into a correctable header-log-overflow error.

Top module: `uerr_hdr_log`

## Requirements
- R1: After reset the status vector, the pointer, both capture registers, the prefix flag and the overflow pulse are all zero.
- R2: A request that is not queued loads the pointer with the bit index of its one-hot status. The status bit is set and the result shows one cycle after the request.
- R3: A request whose header-valid flag is clear loads an all-zero header capture. A request that has the prefix flag set must also have the header flag set.
- R4: Prefix dwords are captured, and the prefix flag is set, only if the request has its prefix flag set and the prefix-support input is high. In every other case the prefix capture is zero.
- R5: If queued recording is enabled and the status bit at the pointer is set, a new request is queued. The pointer and the captures stay the same, and its status bit is still set.
- R6: A request that must be queued while the FIFO holds QDEPTH entries is dropped. Its status bit is still set, and the overflow output is high for exactly one cycle.
- R7: A write that clears the status bit at the pointer, with queued recording enabled and the FIFO not empty, loads the oldest entry into the pointer and the captures. The status bits of all entries that were queued before the write are set again.
- R8: A write that clears the status bit at the pointer, with queued recording disabled or the FIFO empty, sets the pointer, the prefix flag and both captures to zero.
- R9: If the bit at the pointer is still set after a write and queued recording is enabled, the write cannot clear the status bit of any queued error.
- R10: If the bit at the pointer is still set after a write and queued recording is disabled, the FIFO is emptied.
- R11: The capability output is high exactly when QDEPTH is greater than zero. With QDEPTH zero, every request overwrites the captures.
- R12: With queued recording disabled, a new request overwrites the captures even while the earlier error is pending.
- R13: If a write and a request fall in the same cycle, the write is applied first. The request is then judged against the status and pointer that result from the write.
- R14: Queued entries leave the FIFO strictly in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mhr_en | input | 1 | Software enable for queued recording |
| pfx_support | input | 1 | End-to-end prefix support is advertised |
| log_req | input | 1 | One-cycle error capture request |
| log_status | input | 32 | One-hot uncorrectable status of the request |
| log_hdr_vld | input | 1 | Header dwords of the request are valid |
| log_pfx_vld | input | 1 | Prefix dwords of the request are present |
| log_hdr | input | 128 | Four header dwords |
| log_pfx | input | 128 | Four prefix dwords |
| sw_wr | input | 1 | Software write strobe for the status vector |
| sw_clr | input | 32 | Write-one-to-clear mask |
| uncor_status | output | 32 | Uncorrectable status vector |
| first_ptr | output | 5 | Bit index of the captured error |
| hdr_log | output | 128 | Header capture |
| pfx_log | output | 128 | Prefix capture |
| pfx_logged | output | 1 | Prefix capture holds valid dwords |
| mhr_capable | output | 1 | Queued recording is available |
| hdr_ovf | output | 1 | One-cycle overflow pulse |

## Verification
A software clear and a new capture request can arrive in the same cycle. This matters when the clear pops an entry while the request must itself be queued behind the entry it has just exposed. The bench drives both strobes in one cycle while the pointed-to bit is being cleared and the FIFO still holds an entry. It then expects the popped entry in the captures, the new request waiting in the FIFO, and the status bits of both set. A later clear must bring out the new request, which shows it was queued and not dropped or loaded directly.

// File: rtl/uerr_log_pkg.sv
package uerr_log_pkg;
  localparam int STAT_W = 32;
  localparam int PTR_W  = $clog2(STAT_W);
  localparam int DW     = 32;
  localparam int NDW    = 4;
  localparam int LOG_W  = DW * NDW;

  typedef struct packed {
    logic [PTR_W-1:0] ptr;
    logic             hv;
    logic             pv;
    logic [LOG_W-1:0] hdr;
    logic [LOG_W-1:0] pfx;
  } ent_t;

  function automatic logic [PTR_W-1:0] idx_of(input logic [STAT_W-1:0] oh);
    logic [PTR_W-1:0] r;
    r = '0;
    for (int i = 0; i < STAT_W; i++)
      if (oh[i]) r = r | PTR_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/uerr_log_fmt.sv
module uerr_log_fmt
  import uerr_log_pkg::*;
(
  input  ent_t             ent,
  input  logic             pfx_sup,
  output logic [PTR_W-1:0] ptr,
  output logic [LOG_W-1:0] hdr,
  output logic [LOG_W-1:0] pfx,
  output logic             pflag
);
  always_comb begin
    ptr   = ent.ptr;
    pflag = ent.pv & pfx_sup;
    hdr   = ent.hv ? ent.hdr : '0;
    pfx   = pflag ? ent.pfx : '0;
  end
endmodule

// File: rtl/uerr_log_fifo.sv
module uerr_log_fifo
  import uerr_log_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  ent_t                         push_ent,
  input  logic                         pop,
  input  logic                         flush,
  output ent_t                         head,
  output logic [$clog2(DEPTH+2)-1:0]   count,
  output logic [STAT_W-1:0]            pend
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 2);

  ent_t             mem [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_n;
  logic [AW-1:0]    rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0]    cnt_q, cnt_n;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    vld_n = vld_q;
    rd_n  = rd_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (flush) begin
      vld_n = '0;
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else begin
      if (pop) begin
        vld_n[rd_q] = 1'b0;
        rd_n        = inc(rd_q);
      end
      if (push) begin
        vld_n[wr_q] = 1'b1;
        wr_n        = inc(wr_q);
      end
      cnt_n = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_n;
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= push_ent;
  end

  always_comb begin
    pend = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i]) pend[mem[i].ptr] = 1'b1;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

  // R6: nothing enters a full queue unless a slot is freed in the same cycle
  a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)) || pop);
  // R14: only a non-empty queue is popped
  a_r14_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
  // R10: a flush leaves the queue empty
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0) && (vld_q == '0));
  // R14: occupancy count and slot flags agree
  a_r14_cnt_vld: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));
endmodule

// File: rtl/uerr_hdr_log.sv
module uerr_hdr_log
  import uerr_log_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mhr_en,
  input  logic              pfx_support,
  input  logic              log_req,
  input  logic [STAT_W-1:0] log_status,
  input  logic              log_hdr_vld,
  input  logic              log_pfx_vld,
  input  logic [LOG_W-1:0]  log_hdr,
  input  logic [LOG_W-1:0]  log_pfx,
  input  logic              sw_wr,
  input  logic [STAT_W-1:0] sw_clr,
  output logic [STAT_W-1:0] uncor_status,
  output logic [PTR_W-1:0]  first_ptr,
  output logic [LOG_W-1:0]  hdr_log,
  output logic [LOG_W-1:0]  pfx_log,
  output logic              pfx_logged,
  output logic              mhr_capable,
  output logic              hdr_ovf
);
  localparam int  CW    = $clog2(QDEPTH + 2);
  localparam bit  HAS_Q = (QDEPTH > 0);

  logic [STAT_W-1:0] st_q, st_n, st_w;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic [LOG_W-1:0]  hdr_q, hdr_n, pfx_q, pfx_n;
  logic              pf_q, pf_n, ovf_q, ovf_n, log_ld;
  logic              mhr, push, pop, flush, first_hold;
  logic [CW-1:0]     q_cnt, cnt_after;
  logic [STAT_W-1:0] q_pend;
  ent_t              q_head, req_ent;

  logic [PTR_W-1:0]  rq_ptr, hd_ptr;
  logic [LOG_W-1:0]  rq_hdr, rq_pfx, hd_hdr, hd_pfx;
  logic              rq_pf, hd_pf;

  assign mhr = mhr_en & HAS_Q;

  always_comb begin
    req_ent.ptr = idx_of(log_status);
    req_ent.hv  = log_hdr_vld;
    req_ent.pv  = log_pfx_vld;
    req_ent.hdr = log_hdr;
    req_ent.pfx = log_pfx;
  end

  uerr_log_fmt u_fmt_req (.ent(req_ent), .pfx_sup(pfx_support),
    .ptr(rq_ptr), .hdr(rq_hdr), .pfx(rq_pfx), .pflag(rq_pf));
  uerr_log_fmt u_fmt_pop (.ent(q_head), .pfx_sup(pfx_support),
    .ptr(hd_ptr), .hdr(hd_hdr), .pfx(hd_pfx), .pflag(hd_pf));

  generate
    if (HAS_Q) begin : g_q
      uerr_log_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_ent(req_ent),
        .pop(pop), .flush(flush), .head(q_head), .count(q_cnt),
        .pend(q_pend));
    end else begin : g_noq
      assign q_head = '0;
      assign q_cnt  = '0;
      assign q_pend = '0;
    end
  endgenerate

  // next state: the software write is resolved first, then the request
  always_comb begin
    st_w       = st_q & ~(sw_wr ? sw_clr : '0);
    first_hold = st_w[ptr_q];
    st_n   = st_w;
    ptr_n  = ptr_q;
    hdr_n  = hdr_q;
    pfx_n  = pfx_q;
    pf_n   = pf_q;
    log_ld = 1'b0;
    ovf_n  = 1'b0;
    push   = 1'b0;
    pop    = 1'b0;
    flush  = 1'b0;
    if (sw_wr) begin
      if (!first_hold) begin
        log_ld = 1'b1;
        if (mhr && q_cnt != '0) begin
          pop   = 1'b1;
          ptr_n = hd_ptr;
          hdr_n = hd_hdr;
          pfx_n = hd_pfx;
          pf_n  = hd_pf;
          st_n  = st_w | q_pend;
        end else begin
          ptr_n = '0;
          hdr_n = '0;
          pfx_n = '0;
          pf_n  = 1'b0;
        end
      end else if (mhr) begin
        st_n = st_w | q_pend;
      end else begin
        flush = 1'b1;
      end
    end
    cnt_after = flush ? '0 : q_cnt - CW'(pop);
    if (log_req) begin
      if (mhr && st_n[ptr_n]) begin
        if (cnt_after < CW'(QDEPTH)) push  = 1'b1;
        else                         ovf_n = 1'b1;
      end else begin
        log_ld = 1'b1;
        ptr_n  = rq_ptr;
        hdr_n  = rq_hdr;
        pfx_n  = rq_pfx;
        pf_n   = rq_pf;
      end
      st_n = st_n | log_status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      ptr_q <= '0;
      hdr_q <= '0;
      pfx_q <= '0;
      pf_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      ovf_q <= ovf_n;
      if (log_ld) begin
        ptr_q <= ptr_n;
        hdr_q <= hdr_n;
        pfx_q <= pfx_n;
        pf_q  <= pf_n;
      end
    end
  end

  assign uncor_status = st_q;
  assign first_ptr    = ptr_q;
  assign hdr_log      = hdr_q;
  assign pfx_log      = pfx_q;
  assign pfx_logged   = pf_q;
  assign hdr_ovf      = ovf_q;
  assign mhr_capable  = HAS_Q;

  // R2: requests carry exactly one status bit
  a_r2_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> $onehot(log_status));
  // R3: a prefix never arrives without a valid header
  a_r3_pfx_needs_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (log_req && log_pfx_vld) |-> log_hdr_vld);
  // R4: an unflagged prefix capture is empty
  a_r4_pfx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_q |-> (pfx_q == '0));
  // R5: queuing alone leaves the captured error untouched
  a_r5_queue_keeps_log: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> $stable(hdr_q) && $stable(ptr_q) && $stable(pfx_q));
  // R6: overflow only from a full queue with no slot freed
  a_r6_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_n |-> (q_cnt == CW'(QDEPTH)) && !pop);
  // R13: a request is never queued when queued recording is off
  a_r13_push_needs_mhr: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> mhr_en);
endmodule

// File: tb/uerr_hdr_log_bench.sv
module uerr_hdr_log_bench;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic         mhr_en, pfx_support, log_req, log_hdr_vld, log_pfx_vld, sw_wr;
  logic [31:0]  log_status, sw_clr, uncor_status;
  logic [127:0] log_hdr, log_pfx, hdr_log, pfx_log;
  logic [4:0]   first_ptr;
  logic         pfx_logged, mhr_capable, hdr_ovf;

  logic         req2;
  logic [31:0]  st2_in, st2;
  logic [4:0]   ptr2;
  logic [127:0] hl2, pl2;
  logic         pf2, cap2, ovf2;

  uerr_hdr_log #(.QDEPTH(3)) u_uerr_hdr_log (
    .clk(clk), .rst_n(rst_n), .mhr_en(mhr_en), .pfx_support(pfx_support),
    .log_req(log_req), .log_status(log_status), .log_hdr_vld(log_hdr_vld),
    .log_pfx_vld(log_pfx_vld), .log_hdr(log_hdr), .log_pfx(log_pfx),
    .sw_wr(sw_wr), .sw_clr(sw_clr), .uncor_status(uncor_status),
    .first_ptr(first_ptr), .hdr_log(hdr_log), .pfx_log(pfx_log),
    .pfx_logged(pfx_logged), .mhr_capable(mhr_capable), .hdr_ovf(hdr_ovf));

  uerr_hdr_log #(.QDEPTH(0)) u_uerr_hdr_log_nq (
    .clk(clk), .rst_n(rst_n), .mhr_en(1'b1), .pfx_support(1'b1),
    .log_req(req2), .log_status(st2_in), .log_hdr_vld(1'b1),
    .log_pfx_vld(1'b0), .log_hdr(log_hdr), .log_pfx(log_pfx),
    .sw_wr(1'b0), .sw_clr(32'h0), .uncor_status(st2),
    .first_ptr(ptr2), .hdr_log(hl2), .pfx_log(pl2),
    .pfx_logged(pf2), .mhr_capable(cap2), .hdr_ovf(ovf2));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] hpat(input logic [4:0] i);
    return {4{32'hC0DE0000 | 32'(i)}};
  endfunction
  function automatic logic [127:0] ppat(input logic [4:0] i);
    return {4{32'hBEEF0000 | 32'(i)}};
  endfunction

  // op: bit0 request, bit1 status write
  typedef struct packed {
    logic [7:0]  rq;
    logic [1:0]  op;
    logic [4:0]  idx;
    logic        hv;
    logic        pv;
    logic [31:0] clr;
    logic        mhr;
    logic [4:0]  eptr;
    logic [31:0] est;
    logic [4:0]  ehidx;
    logic        ehv;
    logic        epf;
    logic        eovf;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{8'd2,  2'd1, 5'd4,  1'b1, 1'b1, 32'h0,      1'b1, 5'd4,  32'h00000010, 5'd4,  1'b1, 1'b1, 1'b0}, // R2 first capture
    '{8'd5,  2'd1, 5'd7,  1'b1, 1'b0, 32'h0,      1'b1, 5'd4,  32'h00000090, 5'd4,  1'b1, 1'b1, 1'b0}, // R5 queued
    '{8'd5,  2'd1, 5'd12, 1'b0, 1'b0, 32'h0,      1'b1, 5'd4,  32'h00001090, 5'd4,  1'b1, 1'b1, 1'b0}, // R5
    '{8'd5,  2'd1, 5'd2,  1'b1, 1'b1, 32'h0,      1'b1, 5'd4,  32'h00001094, 5'd4,  1'b1, 1'b1, 1'b0}, // R5 queue full
    '{8'd6,  2'd1, 5'd20, 1'b1, 1'b0, 32'h0,      1'b1, 5'd4,  32'h00101094, 5'd4,  1'b1, 1'b1, 1'b1}, // R6 overflow
    '{8'd9,  2'd2, 5'd0,  1'b0, 1'b0, 32'h1080,   1'b1, 5'd4,  32'h00101094, 5'd4,  1'b1, 1'b1, 1'b0}, // R9, R6 pulse ends
    '{8'd7,  2'd2, 5'd0,  1'b0, 1'b0, 32'h10,     1'b1, 5'd7,  32'h00101084, 5'd7,  1'b1, 1'b0, 1'b0}, // R7 pop oldest
    '{8'd3,  2'd2, 5'd0,  1'b0, 1'b0, 32'h80,     1'b1, 5'd12, 32'h00101004, 5'd0,  1'b0, 1'b0, 1'b0}, // R3 zero header
    '{8'd13, 2'd3, 5'd9,  1'b1, 1'b1, 32'h1000,   1'b1, 5'd2,  32'h00100204, 5'd2,  1'b1, 1'b1, 1'b0}, // R13 same cycle
    '{8'd14, 2'd2, 5'd0,  1'b0, 1'b0, 32'h4,      1'b1, 5'd9,  32'h00100200, 5'd9,  1'b1, 1'b1, 1'b0}, // R14 order
    '{8'd8,  2'd2, 5'd0,  1'b0, 1'b0, 32'h200,    1'b1, 5'd0,  32'h00100000, 5'd0,  1'b0, 1'b0, 1'b0}, // R8 empty queue
    '{8'd8,  2'd2, 5'd0,  1'b0, 1'b0, 32'h100000, 1'b1, 5'd0,  32'h00000000, 5'd0,  1'b0, 1'b0, 1'b0}, // R8
    '{8'd12, 2'd1, 5'd5,  1'b1, 1'b1, 32'h0,      1'b0, 5'd5,  32'h00000020, 5'd5,  1'b1, 1'b1, 1'b0}, // R12
    '{8'd12, 2'd1, 5'd6,  1'b1, 1'b0, 32'h0,      1'b0, 5'd6,  32'h00000060, 5'd6,  1'b1, 1'b0, 1'b0}, // R12 overwrite
    '{8'd5,  2'd1, 5'd3,  1'b1, 1'b0, 32'h0,      1'b1, 5'd6,  32'h00000068, 5'd6,  1'b1, 1'b0, 1'b0}, // R5
    '{8'd10, 2'd2, 5'd0,  1'b0, 1'b0, 32'h0,      1'b0, 5'd6,  32'h00000068, 5'd6,  1'b1, 1'b0, 1'b0}, // R10 flush
    '{8'd10, 2'd2, 5'd0,  1'b0, 1'b0, 32'h40,     1'b1, 5'd0,  32'h00000028, 5'd0,  1'b0, 1'b0, 1'b0}, // R10 nothing left
    '{8'd8,  2'd2, 5'd0,  1'b0, 1'b0, 32'h28,     1'b1, 5'd0,  32'h00000000, 5'd0,  1'b0, 1'b0, 1'b0}  // R8
  };

  task automatic idle();
    log_req = 1'b0; sw_wr = 1'b0; sw_clr = '0; log_status = '0;
    log_hdr_vld = 1'b0; log_pfx_vld = 1'b0; req2 = 1'b0; st2_in = '0;
  endtask

  task automatic drive_req(input logic [4:0] i, input logic hv, input logic pv);
    log_req = 1'b1; log_status = 32'h1 << i; log_hdr_vld = hv; log_pfx_vld = pv;
    log_hdr = hpat(i); log_pfx = ppat(i);
  endtask

  initial begin
    rst_n = 1'b0; mhr_en = 1'b1; pfx_support = 1'b1;
    log_hdr = '0; log_pfx = '0;
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", 128'(uncor_status), 128'h0);
    chk("R1 pointer", 128'(first_ptr), 128'h0);
    chk("R1 header", hdr_log, 128'h0);
    chk("R1 prefix", {pfx_log[126:0], pfx_logged}, 128'h0);
    chk("R1 overflow", 128'(hdr_ovf), 128'h0);
    rst_n = 1'b1;
    // R11 capability
    chk("R11 capable q3", 128'(mhr_capable), 128'h1);
    chk("R11 capable q0", 128'(cap2), 128'h0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      idle();
      mhr_en = TBL[v].mhr;
      if (TBL[v].op[0]) drive_req(TBL[v].idx, TBL[v].hv, TBL[v].pv);
      if (TBL[v].op[1]) begin sw_wr = 1'b1; sw_clr = TBL[v].clr; end
      @(negedge clk);
      idle();
      chk($sformatf("R%0d row %0d pointer", TBL[v].rq, v), 128'(first_ptr), 128'(TBL[v].eptr));
      chk($sformatf("R%0d row %0d status", TBL[v].rq, v), 128'(uncor_status), 128'(TBL[v].est));
      chk($sformatf("R%0d row %0d header", TBL[v].rq, v), hdr_log,
          TBL[v].ehv ? hpat(TBL[v].ehidx) : 128'h0);
      chk($sformatf("R%0d row %0d prefix", TBL[v].rq, v), pfx_log,
          TBL[v].epf ? ppat(TBL[v].ehidx) : 128'h0);
      chk($sformatf("R%0d row %0d prefix flag", TBL[v].rq, v), 128'(pfx_logged), 128'(TBL[v].epf));
      chk($sformatf("R%0d row %0d overflow", TBL[v].rq, v), 128'(hdr_ovf), 128'(TBL[v].eovf));
    end

    // R4: prefix present but support not advertised
    pfx_support = 1'b0; mhr_en = 1'b1;
    drive_req(5'd1, 1'b1, 1'b1);
    @(negedge clk);
    idle();
    chk("R4 no support pointer", 128'(first_ptr), 128'd1);
    chk("R4 no support header", hdr_log, hpat(5'd1));
    chk("R4 no support prefix", pfx_log, 128'h0);
    chk("R4 no support flag", 128'(pfx_logged), 128'h0);
    pfx_support = 1'b1;

    // R11: without a queue every request overwrites, even with enable set
    req2 = 1'b1; st2_in = 32'h10; log_hdr = hpat(5'd4);
    @(negedge clk);
    req2 = 1'b1; st2_in = 32'h80; log_hdr = hpat(5'd7);
    @(negedge clk);
    idle();
    chk("R11 no queue pointer", 128'(ptr2), 128'd7);
    chk("R11 no queue header", hl2, hpat(5'd7));
    chk("R11 no queue status", 128'(st2), 128'h90);
    chk("R11 no queue overflow", 128'(ovf2), 128'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule